// File: doc/BRIEF.md
# Four-Phase Handshake Bus Controller

This block moves single read and write transfers across a return-to-zero request/acknowledge bus. It has two halves that run on unrelated clocks. The requester half takes one command at a time from a local valid/ready port. It places the address, the direction and, for a write, the data on the bus. It then holds them for a programmed settle time so that responders can decode the address. Only after that does it raise request. It waits for acknowledge, drops request, waits for acknowledge to drop, and then reports completion. A write completes with a one-cycle done pulse; a read completes with its data and a one-cycle valid pulse.

The responder half is a small register bank that answers a fixed address window. Each half passes the handshake line it receives from the other half through a two-flop synchronizer. Read data is qualified by acknowledge rather than by a shared clock. The requester stops driving the data lines for the whole of a read, so that the responder can drive them.

Top module: `hsb_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_ready` is 1, `bus_req` and `bus_ack` are 0, neither data driver is enabled, and `rsp_wdone` and `rsp_rvalid` are 0.
- R2: When a command is accepted (`cmd_valid` and `cmd_ready` both 1 at a rising edge of `m_clk`), the address and direction appear on the bus at that edge. `bus_rnw` is 1 for a read and 0 for a write. For a write, `bus_m_oe` is 1 and `bus_data` carries the write data, all before `bus_req` rises.
- R3: `bus_req` rises exactly SETTLE rising edges of `m_clk` after the accepting edge, where SETTLE is a parameter of at least 1.
- R4: The responder raises `bus_ack` only after it has seen `bus_req` high. On a write, it stores `bus_data` into the word selected by the low IW address bits at that point.
- R5: During a read, `bus_m_oe` stays 0. The responder drives the stored word (`bus_s_oe` = 1) while request is high for a selected read. The two drivers are never enabled together.
- R6: The requester drops `bus_req` only after its synchronized copy of acknowledge is high. On a read, it captures `bus_data` at that point and later presents it on `rsp_rdata`.
- R7: The responder drops `bus_ack` only after its synchronized copy of request is low. Once the requester sees acknowledge low, it pulses `rsp_wdone` (write) or `rsp_rvalid` (read) for one `m_clk` cycle. In the same cycle it shows `cmd_ready` = 1.
- R8: `cmd_ready` is 1 only when `bus_req` and acknowledge are both 0. `bus_addr` and `bus_rnw` do not change while `bus_req` is high.
- R9: The responder answers only when the upper AW-IW address bits equal the SEL parameter. A command to any other address never sees acknowledge, produces no response pulse, and is cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| m_clk | input | 1 | Requester clock |
| m_rst_n | input | 1 | Requester synchronous reset, active low |
| s_clk | input | 1 | Responder clock |
| s_rst_n | input | 1 | Responder synchronous reset, active low |
| cmd_valid | input | 1 | Local command present |
| cmd_ready | output | 1 | Requester can accept a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Command address |
| cmd_wdata | input | DW | Write data |
| rsp_rdata | output | DW | Last read data |
| rsp_rvalid | output | 1 | One-cycle pulse: read finished |
| rsp_wdone | output | 1 | One-cycle pulse: write finished |
| bus_req | output | 1 | Bus request line (observation) |
| bus_ack | output | 1 | Bus acknowledge line (observation) |
| bus_rnw | output | 1 | Bus direction, 1 = read (observation) |
| bus_addr | output | AW | Bus address (observation) |
| bus_data | output | DW | Resolved bus data (observation) |
| bus_m_oe | output | 1 | Requester drives data (observation) |
| bus_s_oe | output | 1 | Responder drives data (observation) |

## Verification
The handshake-order assertions assume a few things about the inputs. The address, direction and write data come only from the requester's held registers. Each clock is free-running while its side is out of reset. The two resets are released before any command is offered. The stimulus meets these by resetting both sides together, offering a command only at a falling edge of `m_clk` while `cmd_ready` is 1, and holding `cmd_valid` for exactly one rising edge. Commands to an address outside the responder's window are sent only as the last step, because such a command can only be cleared by reset.

// File: rtl/hsb_pkg.sv
// Shared types for the four-phase handshake bus.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package hsb_pkg;

    // Requester sequencing states
    typedef enum logic [1:0] {
        M_IDLE    = 2'd0,
        M_SETTLE  = 2'd1,
        M_REQ     = 2'd2,
        M_RELEASE = 2'd3
    } m_state_t;

    // Responder sequencing states
    typedef enum logic {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } s_state_t;

endpackage

// File: rtl/hsb_sync2.sv
// Two-flop synchronizer for one handshake line entering a clock domain.
// Assumes: the input changes at most once per two destination cycles
// (it is a level handshake), so no pulse stretching is needed.
module hsb_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;
    logic out_q;

    // Shift the asynchronous level through two stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            out_q  <= 1'b0;
        end else begin
            meta_q <= d;
            out_q  <= meta_q;
        end
    end

    assign q = out_q;
endmodule

// File: rtl/hsb_master.sv
// Requester side: accepts one local command, drives address/direction
// (and write data), waits SETTLE cycles, then runs req/ack return-to-zero.
// Assumes: SETTLE >= 1; ack_s is already synchronized to clk.
module hsb_master
    import hsb_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 32,
    parameter int SETTLE = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_rvalid,
    output logic          rsp_wdone,
    input  logic          ack_s,
    input  logic [DW-1:0] bus_din,
    output logic          req,
    output logic          rnw,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] dout,
    output logic          oe
);
    localparam int CW = (SETTLE < 2) ? 1 : $clog2(SETTLE);
    localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE - 1);

    m_state_t      state_q;
    logic [CW-1:0] cnt_q;
    logic          req_q, rnw_q, oe_q, rvalid_q, wdone_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic          accept;

    // A command may start only with both handshake lines at rest
    assign cmd_ready = (state_q == M_IDLE) && !req_q && !ack_s;
    assign accept    = cmd_valid && cmd_ready;

    // Sequence one transfer through settle, request and release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= M_IDLE;
            cnt_q    <= '0;
            req_q    <= 1'b0;
            rnw_q    <= 1'b1;
            oe_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
            wdone_q  <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            wdone_q  <= 1'b0;
            unique case (state_q)
                M_IDLE: begin
                    if (accept) begin
                        addr_q  <= cmd_addr;
                        rnw_q   <= !cmd_write;
                        wdata_q <= cmd_wdata;
                        oe_q    <= cmd_write;
                        cnt_q   <= '0;
                        state_q <= M_SETTLE;
                    end
                end
                M_SETTLE: begin
                    if (cnt_q == CNT_LAST) begin
                        req_q   <= 1'b1;
                        state_q <= M_REQ;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                M_REQ: begin
                    if (ack_s) begin
                        req_q <= 1'b0;
                        if (rnw_q) rdata_q <= bus_din;
                        state_q <= M_RELEASE;
                    end
                end
                M_RELEASE: begin
                    if (!ack_s) begin
                        oe_q     <= 1'b0;
                        rvalid_q <= rnw_q;
                        wdone_q  <= !rnw_q;
                        state_q  <= M_IDLE;
                    end
                end
                default: state_q <= M_IDLE;
            endcase
        end
    end

    assign req        = req_q;
    assign rnw        = rnw_q;
    assign addr       = addr_q;
    assign dout       = wdata_q;
    assign oe         = oe_q;
    assign rsp_rdata  = rdata_q;
    assign rsp_rvalid = rvalid_q;
    assign rsp_wdone  = wdone_q;

    // R8
    req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> !ack_s);
    // R6
    req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q) |-> $past(ack_s));
    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && $past(req_q)) |-> ($stable(addr_q) && $stable(rnw_q)));
    // R5
    no_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> !rnw_q);
    // R7
    one_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rvalid_q && wdone_q));
endmodule

// File: rtl/hsb_slave.sv
// Responder side: a register bank answering one address window. Raises
// ack after a synchronized request, stores write data at that point, and
// drives read data while a selected read request is seen high.
// Assumes: address, direction and write data are stable while req is high.
module hsb_slave
    import hsb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32,
    parameter int IW = 4,
    parameter logic [AW-IW-1:0] SEL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_s,
    input  logic          rnw,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] bus_din,
    output logic          ack,
    output logic [DW-1:0] dout,
    output logic          oe
);
    localparam int DEPTH = 1 << IW;

    s_state_t      state_q;
    logic          ack_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          sel;
    logic [IW-1:0] idx;

    assign sel = (addr[AW-1:IW] == SEL);
    assign idx = addr[IW-1:0];

    // Answer a request, then wait for it to return to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ack_q   <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_s && sel) begin
                    ack_q   <= 1'b1;
                    state_q <= S_ACK;
                end
                S_ACK: if (!req_s) begin
                    ack_q   <= 1'b0;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Store write data as acknowledge is raised
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (state_q == S_IDLE && req_s && sel && !rnw) begin
            mem_q[idx] <= bus_din;
        end
    end

    assign ack  = ack_q;
    assign oe   = req_s && rnw && sel;
    assign dout = mem_q[idx];

    // R4
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> $past(req_s));
    // R7
    ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_q) |-> !$past(req_s));
    // R9
    unsel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !ack_q) |=> !ack_q);
endmodule

// File: rtl/hsb_top.sv
// Top: requester and responder on separate clocks, each with a two-flop
// synchronizer on the handshake line it receives, and the shared data
// lines resolved from the two driver enables.
// Assumes: both resets are applied together before first use.
module hsb_top #(
    parameter int AW     = 8,
    parameter int DW     = 32,
    parameter int IW     = 4,
    parameter logic [AW-IW-1:0] SEL = 4'hA,
    parameter int SETTLE = 3
) (
    input  logic          m_clk,
    input  logic          m_rst_n,
    input  logic          s_clk,
    input  logic          s_rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_rvalid,
    output logic          rsp_wdone,
    output logic          bus_req,
    output logic          bus_ack,
    output logic          bus_rnw,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_data,
    output logic          bus_m_oe,
    output logic          bus_s_oe
);
    logic          req, ack, rnw, m_oe, s_oe, ack_s, req_s;
    logic [AW-1:0] addr;
    logic [DW-1:0] m_dout, s_dout, data;

    // Resolve the shared data lines; nobody driving reads as zero
    assign data = m_oe ? m_dout : (s_oe ? s_dout : '0);

    hsb_sync2 u_ack_sync (.clk(m_clk), .rst_n(m_rst_n), .d(ack), .q(ack_s));
    hsb_sync2 u_req_sync (.clk(s_clk), .rst_n(s_rst_n), .d(req), .q(req_s));

    hsb_master #(.AW(AW), .DW(DW), .SETTLE(SETTLE)) u_master (
        .clk(m_clk), .rst_n(m_rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_rdata(rsp_rdata), .rsp_rvalid(rsp_rvalid), .rsp_wdone(rsp_wdone),
        .ack_s(ack_s), .bus_din(data),
        .req(req), .rnw(rnw), .addr(addr), .dout(m_dout), .oe(m_oe)
    );

    hsb_slave #(.AW(AW), .DW(DW), .IW(IW), .SEL(SEL)) u_slave (
        .clk(s_clk), .rst_n(s_rst_n),
        .req_s(req_s), .rnw(rnw), .addr(addr), .bus_din(data),
        .ack(ack), .dout(s_dout), .oe(s_oe)
    );

    assign bus_req  = req;
    assign bus_ack  = ack;
    assign bus_rnw  = rnw;
    assign bus_addr = addr;
    assign bus_data = data;
    assign bus_m_oe = m_oe;
    assign bus_s_oe = s_oe;

    // R5
    no_contend_chk: assert property (@(posedge m_clk) disable iff (!m_rst_n)
        !(m_oe && s_oe));
    // R2
    drive_before_req_chk: assert property (@(posedge m_clk) disable iff (!m_rst_n)
        $rose(req) |-> $past(m_oe) == !rnw);
endmodule

// File: tb/tb_hsb_top.sv
module tb_hsb_top;
    localparam int AW = 8, DW = 32, IW = 4, SETTLE = 3;
    localparam logic [AW-IW-1:0] SEL = 4'hA;

    logic m_clk = 0, s_clk = 0, m_rst_n = 0, s_rst_n = 0;
    logic cmd_valid = 0, cmd_write = 0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic cmd_ready, rsp_rvalid, rsp_wdone, bus_req, bus_ack, bus_rnw, bus_m_oe, bus_s_oe;
    logic [DW-1:0] rsp_rdata, bus_data;
    logic [AW-1:0] bus_addr;

    always #2 m_clk = ~m_clk;      // 250 MHz
    always #3.5 s_clk = ~s_clk;

    hsb_top #(.AW(AW), .DW(DW), .IW(IW), .SEL(SEL), .SETTLE(SETTLE)) dut (.*);

    typedef struct { logic wr; logic [AW-1:0] a; logic [DW-1:0] d; } item_t;
    item_t exp_q[$];
    logic [DW-1:0] model [1 << IW];
    int checks = 0, errors = 0;
    logic mon_on = 0, done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: offer one command, push the expected result
    task automatic send(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        item_t it;
        @(negedge m_clk);
        while (!cmd_ready) @(negedge m_clk);
        cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        it.wr = wr; it.a = a;
        if (wr) begin model[a[IW-1:0]] = d; it.d = d; end
        else it.d = model[a[IW-1:0]];
        exp_q.push_back(it);
        @(negedge m_clk);
        cmd_valid = 0;
        // R2: accepted command is on the bus before request
        chk(bus_addr == a && bus_rnw == !wr && bus_m_oe == wr && !bus_req,
            "R2", "bus setup", {bus_addr, 3'b0, bus_rnw, bus_m_oe, bus_req}, {a, 3'b0, !wr, wr, 1'b0});
        if (wr) chk(bus_data == d, "R2", "write data", bus_data, d);
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 2000) begin @(negedge m_clk); n++; end
        chk(exp_q.size() == 0, "R7", "queue drained", exp_q.size(), 0);
    endtask

    // Monitor: compare responses, settle time, ordering rules
    int settle_cnt = 0;
    logic armed = 0, prev_ready = 1;
    always @(negedge m_clk) if (mon_on) begin
        item_t it;
        if (rsp_wdone || rsp_rvalid) begin
            if (exp_q.size() == 0) chk(0, "R7", "unexpected response", 1, 0);
            else begin
                it = exp_q.pop_front();
                chk(cmd_ready, "R7", "ready with completion", cmd_ready, 1);
                if (it.wr) chk(rsp_wdone && !rsp_rvalid, "R7", "write done pulse", rsp_rvalid, 0);
                else begin
                    chk(rsp_rvalid && !rsp_wdone, "R7", "read valid pulse", rsp_wdone, 0);
                    chk(rsp_rdata == it.d, "R6", "read data", rsp_rdata, it.d);
                end
            end
        end
        if (cmd_ready) chk(!bus_req && !bus_ack, "R8", "ready with lines at rest", {bus_req, bus_ack}, 0);
        if (bus_req && bus_rnw) chk(!bus_m_oe, "R5", "requester off during read", bus_m_oe, 0);
        if (bus_req && bus_ack && bus_rnw && exp_q.size() != 0)
            chk(bus_s_oe && bus_data == exp_q[0].d, "R5", "responder read data", bus_data, exp_q[0].d);
        if (prev_ready && !cmd_ready) begin armed = 1; settle_cnt = 0; end
        if (armed) begin
            if (bus_req) begin
                chk(settle_cnt == SETTLE, "R3", "settle cycles", settle_cnt, SETTLE);
                armed = 0;
            end else settle_cnt++;
        end
        prev_ready = cmd_ready;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge m_clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << IW); i++) model[i] = '0;
        repeat (6) @(negedge m_clk);
        // R1: reset state
        chk(cmd_ready && !bus_req && !bus_ack && !bus_m_oe && !bus_s_oe && !rsp_wdone && !rsp_rvalid,
            "R1", "reset state", {cmd_ready, bus_req, bus_ack, bus_m_oe, bus_s_oe}, 5'b10000);
        @(negedge s_clk); s_rst_n = 1;
        @(negedge m_clk); m_rst_n = 1;
        @(negedge m_clk);
        chk(cmd_ready && !bus_req && !rsp_rvalid, "R1", "after reset", cmd_ready, 1);
        mon_on = 1;
        // R4 write then read back
        send(1, 8'hA3, 32'hDEAD_BEEF);
        send(0, 8'hA3, 'x);
        send(0, 8'hA7, 'x);      // never written: zero
        send(1, 8'hA0, 32'h0000_0000);
        send(1, 8'hAF, 32'hFFFF_FFFF);
        send(1, 8'hA5, 32'h1234_5678);
        send(0, 8'hAF, 'x);
        send(0, 8'hA0, 'x);
        send(0, 8'hA5, 'x);
        for (int k = 0; k < 8; k++) send(1, {SEL, 4'(k * 2)}, 32'hC0DE_0000 + k);
        for (int k = 7; k >= 0; k--) send(0, {SEL, 4'(k * 2)}, 'x);
        send(1, 8'hA3, 32'h5555_AAAA);
        send(0, 8'hA3, 'x);
        drain();
        // R9: address outside the window never completes
        mon_on = 0;
        @(negedge m_clk);
        cmd_valid = 1; cmd_write = 0; cmd_addr = 8'h31;
        @(negedge m_clk); cmd_valid = 0;
        begin
            int seen = 0;
            repeat (200) begin
                @(negedge m_clk);
                if (bus_ack || rsp_rvalid || rsp_wdone || bus_s_oe) seen++;
            end
            chk(seen == 0, "R9", "unselected quiet", seen, 0);
            chk(bus_req && !cmd_ready, "R9", "unselected stays pending", {bus_req, cmd_ready}, 2'b10);
        end
        m_rst_n = 0; s_rst_n = 0;
        repeat (4) @(negedge s_clk);
        s_rst_n = 1; m_rst_n = 1;
        repeat (2) @(negedge m_clk);
        chk(cmd_ready && !bus_req, "R9", "reset clears pending", {cmd_ready, bus_req}, 2'b10);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule